// File: doc/BRIEF.md
# Intra 16x16 Luma Mode Sequencer with Ping-Pong Residual Store

This block runs the mode decision for one 16x16 luma macroblock using intra prediction, with no rate-distortion optimisation. A start pulse loads a 2-bit neighbour availability code. The block then steps through every prediction mode that the code allows, always in the same order. For each mode it presents the mode index on `cur_mode`. An external predictor returns that mode's 256 residual samples, and an external cost unit then returns one cost value.

The block has two residual memories. One holds the residuals of the best mode found so far. The other receives the residuals of the mode under test. When the cost arrives, a strictly cheaper mode takes the best role, and its memory swaps roles with the other one. Otherwise the rejected residuals are simply overwritten by the next mode. After the last allowed mode, the block pulses `done`, reports the chosen mode and streams the winning residuals to the transform stage. No extra pass over the data is needed.

The residual input, the cost input and the residual output are valid/ready channels. A transfer happens on a rising clock edge where both valid and ready are high. The ready signals of the block never depend combinationally on the valid inputs. On the output, back-pressure is unlimited: while `out_ready` is low, the current word and its `out_last` flag stay unchanged until they are taken.

Top module: `intra16_mode_seq`

## Requirements
- R1: After reset, and whenever no run is active, `busy`, `in_ready`, `cost_ready`, `out_valid` and `done` are all low.
- R2: The availability code has bit 1 set when top neighbours exist and bit 0 set when left neighbours exist. DC is always tried, vertical needs top, horizontal needs left, and plane needs both.
- R3: Mode indices are 0 vertical, 1 horizontal, 2 DC, 3 plane. The allowed modes are tried in the order DC, horizontal, vertical, plane. `cur_mode` shows the mode under test while `in_ready` is high.
- R4: Each tried mode accepts exactly 256 residual samples and then exactly one cost. While residuals are being accepted, `cost_ready` is low, and `in_ready` is never high together with `cost_ready`.
- R5: The first tried mode always becomes the best. A later mode replaces it only if its cost is strictly smaller, so on a tie the earlier mode is kept.
- R6: `done` is a one-cycle pulse in the first cycle of `out_valid`. `best_mode` holds the chosen mode from that cycle until a new run starts.
- R7: The output stream carries the 256 residuals of the chosen mode, in the order they were received. `out_last` is high on the 256th word only.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_valid` stay unchanged on the next cycle.
- R9: A start pulse that arrives while `busy` is high is ignored. The run in progress keeps its availability code and its mode order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| avail | input | 2 | Neighbour availability, bit 1 top, bit 0 left |
| busy | output | 1 | A run is in progress |
| cur_mode | output | 2 | Mode whose residuals are expected now |
| in_valid | input | 1 | Residual sample valid |
| in_ready | output | 1 | Residual sample can be accepted |
| in_data | input | 9 | Signed residual sample |
| cost_valid | input | 1 | Cost of the current mode is valid |
| cost_ready | output | 1 | Block waits for the current mode's cost |
| cost_data | input | 16 | Unsigned cost value |
| done | output | 1 | Decision made, output stream begins |
| best_mode | output | 2 | Chosen mode index |
| out_valid | output | 1 | Winning residual valid |
| out_ready | input | 1 | Downstream accepts the residual |
| out_data | output | 9 | Winning residual sample |
| out_last | output | 1 | Final residual of the block |

## Verification
The hardest case to reach from the ports is a winner that is followed by a losing mode, so that the losing mode's residuals are written into the other memory while the winner's memory must stay untouched. A second hard case is a winner that comes after one or more swaps of the memory roles. Directed runs with all neighbours available drive costs chosen so that the best mode changes, then holds against a worse candidate, then holds again. Each mode's residuals follow a pattern unique to that mode, so any read from the wrong memory, or any overwrite of the kept data, shows up in the output stream. Random stalls on the output and a stray start pulse in the middle of a run cover back-pressure and the ignore rule.

// File: rtl/intra16_seq_pkg.sv
package intra16_seq_pkg;

  localparam logic [1:0] MODE_VERT  = 2'd0;
  localparam logic [1:0] MODE_HORZ  = 2'd1;
  localparam logic [1:0] MODE_DC    = 2'd2;
  localparam logic [1:0] MODE_PLANE = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_COST = 2'd2,
    ST_SEND = 2'd3
  } seq_state_t;

  // trial order: step 0 DC, 1 horizontal, 2 vertical, 3 plane
  function automatic logic [1:0] step_to_mode(input logic [1:0] step);
    case (step)
      2'd0:    return MODE_DC;
      2'd1:    return MODE_HORZ;
      2'd2:    return MODE_VERT;
      default: return MODE_PLANE;
    endcase
  endfunction

  // av[1] = top neighbours present, av[0] = left neighbours present
  function automatic logic mode_usable(input logic [1:0] mode, input logic [1:0] av);
    case (mode)
      MODE_DC:   return 1'b1;
      MODE_VERT: return av[1];
      MODE_HORZ: return av[0];
      default:   return av[1] & av[0];
    endcase
  endfunction

endpackage

// File: rtl/intra16_mode_order.sv
module intra16_mode_order
  import intra16_seq_pkg::*;
#(
  parameter int N_STEPS = 4
) (
  input  logic [1:0] avail,
  input  logic [1:0] step,
  output logic [1:0] first_step,
  output logic       first_ok,
  output logic [1:0] next_step,
  output logic       next_ok
);

  always_comb begin
    first_ok   = 1'b0;
    first_step = 2'd0;
    next_ok    = 1'b0;
    next_step  = 2'd0;
    // walk downward so the lowest qualifying step is kept
    for (int k = N_STEPS - 1; k >= 0; k--) begin
      if (mode_usable(step_to_mode(2'(k)), avail)) begin
        first_ok   = 1'b1;
        first_step = 2'(k);
        if (k > int'(step)) begin
          next_ok   = 1'b1;
          next_step = 2'(k);
        end
      end
    end
  end

endmodule

// File: rtl/intra16_res_ram.sv
module intra16_res_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/intra16_best_track.sv
module intra16_best_track #(
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [COST_W-1:0] cost,
  input  logic [1:0]        mode,
  output logic              best_sel,
  output logic              test_sel,
  output logic [1:0]        best_mode
);

  logic              have_best;
  logic [COST_W-1:0] best_cost;
  logic              wins;

  assign wins = !have_best || (cost < best_cost);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_best <= 1'b0;
      best_cost <= '0;
      best_sel  <= 1'b0;
      test_sel  <= 1'b0;
      best_mode <= 2'd0;
    end else if (clear) begin
      have_best <= 1'b0;
      test_sel  <= 1'b0;
    end else if (take) begin
      have_best <= 1'b1;
      if (wins) begin
        best_cost <= cost;
        best_mode <= mode;
        best_sel  <= test_sel;
        test_sel  <= ~test_sel;
      end
    end
  end

  // R5: the kept cost never grows within a run
  p_cost_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (have_best && take && !clear) |=> (best_cost <= $past(best_cost)));

  // R5: once a best exists, the write memory differs from the kept one
  p_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (have_best && !clear) |-> (best_sel != test_sel));

endmodule

// File: rtl/intra16_mode_seq.sv
module intra16_mode_seq
  import intra16_seq_pkg::*;
#(
  parameter int N_PIX   = 256,
  parameter int DATA_W  = 9,
  parameter int COST_W  = 16,
  parameter int N_STEPS = 4,
  parameter int N_BUF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        avail,
  output logic              busy,
  output logic [1:0]        cur_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cost_valid,
  output logic              cost_ready,
  input  logic [COST_W-1:0] cost_data,
  output logic              done,
  output logic [1:0]        best_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);

  localparam int AW = $clog2(N_PIX);
  localparam logic [AW-1:0] LAST_IDX = AW'(N_PIX - 1);

  seq_state_t    state;
  logic [1:0]    avail_q;
  logic [1:0]    step;
  logic [AW-1:0] wr_cnt;
  logic [AW-1:0] rd_cnt;
  logic          done_q;

  logic [1:0]    first_step, next_step;
  logic          first_ok, next_ok;
  logic          best_sel, test_sel;
  logic          launch, in_take, cost_take, out_take;

  assign launch    = (state == ST_IDLE) && start;
  assign in_take   = in_valid && in_ready;
  assign cost_take = cost_valid && cost_ready;
  assign out_take  = out_valid && out_ready;

  // a new run reads the fresh code, a running one its latched copy
  intra16_mode_order #(.N_STEPS(N_STEPS)) u_order (
    .avail      (launch ? avail : avail_q),
    .step       (step),
    .first_step (first_step),
    .first_ok   (first_ok),
    .next_step  (next_step),
    .next_ok    (next_ok)
  );

  intra16_best_track #(.COST_W(COST_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .take      (cost_take),
    .cost      (cost_data),
    .mode      (cur_mode),
    .best_sel  (best_sel),
    .test_sel  (test_sel),
    .best_mode (best_mode)
  );

  logic [DATA_W-1:0] buf_rd [N_BUF];

  for (genvar g = 0; g < N_BUF; g++) begin : g_buf
    intra16_res_ram #(.DEPTH(N_PIX), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (in_take && (int'(test_sel) == g)),
      .waddr (wr_cnt),
      .wdata (in_data),
      .raddr (rd_cnt),
      .rdata (buf_rd[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      avail_q <= 2'b00;
      step    <= 2'd0;
      wr_cnt  <= '0;
      rd_cnt  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && first_ok) begin
            avail_q <= avail;
            step    <= first_step;
            wr_cnt  <= '0;
            state   <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (in_take) begin
            if (wr_cnt == LAST_IDX) begin
              wr_cnt <= '0;
              state  <= ST_COST;
            end else begin
              wr_cnt <= wr_cnt + 1'b1;
            end
          end
        end
        ST_COST: begin
          if (cost_take) begin
            if (next_ok) begin
              step  <= next_step;
              state <= ST_RECV;
            end else begin
              rd_cnt <= '0;
              done_q <= 1'b1;
              state  <= ST_SEND;
            end
          end
        end
        default: begin
          if (out_take) begin
            if (rd_cnt == LAST_IDX) begin
              rd_cnt <= '0;
              state  <= ST_IDLE;
            end else begin
              rd_cnt <= rd_cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign cur_mode   = step_to_mode(step);
  assign in_ready   = (state == ST_RECV);
  assign cost_ready = (state == ST_COST);
  assign out_valid  = (state == ST_SEND);
  assign out_data   = buf_rd[best_sel];
  assign out_last   = out_valid && (rd_cnt == LAST_IDX);
  assign done       = done_q;

  // R1: idle means every channel is quiet
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !cost_ready && !out_valid && !done));

  // R2: only permitted modes are presented to the predictor
  p_mode_allowed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> mode_usable(cur_mode, avail_q));

  // R4: residual intake and cost intake never overlap
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && cost_ready));

  // R6: the decision pulse coincides with the first output word
  p_done_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && !$past(out_valid)));

  // R6: best_mode is frozen while the winning residuals stream out
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(best_mode));

  // R8: stalled output word stays put
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9: the latched availability code survives the whole run
  p_avail_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(avail_q));

endmodule

// File: tb/intra16_mode_seq_test.sv
module intra16_mode_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] avail = 2'b00;
  logic       busy;
  logic [1:0] cur_mode;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic       cost_valid = 1'b0;
  logic       cost_ready;
  logic [15:0] cost_data = '0;
  logic       done;
  logic [1:0] best_mode;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [8:0] out_data;
  logic       out_last;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  intra16_mode_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .avail(avail), .busy(busy),
    .cur_mode(cur_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cost_valid(cost_valid), .cost_ready(cost_ready),
    .cost_data(cost_data), .done(done), .best_mode(best_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] pat(input int m, input int i);
    return 9'((i * 7 + m * 61 + 13) % 512);
  endfunction

  // seq: modes in trial order, packed 2 bits per step; costs per step
  task automatic run_case(input string name, input logic [1:0] av,
                          input logic [7:0] seq, input int nmodes,
                          input int costs[4], input bit stall, input bit stray);
    int exp_best;
    int best_c;
    int to;
    int bad_data;
    int bad_last;
    int bad_hold;
    bit cost_seen;
    bit held;
    logic [8:0] held_data;
    // expected winner: first strictly smallest cost in trial order
    exp_best = int'(seq[1:0]);
    best_c = costs[0];
    for (int k = 1; k < nmodes; k++) begin
      if (costs[k] < best_c) begin
        best_c = costs[k];
        exp_best = int'(seq[2*k +: 2]);
      end
    end
    @(negedge clk);
    avail = av;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    avail = ~av;
    for (int k = 0; k < nmodes; k++) begin
      int i;
      to = 0;
      while (!in_ready && to < 2000) begin
        @(negedge clk);
        to++;
      end
      check(int'(cur_mode) == int'(seq[2*k +: 2]), "R3",
            $sformatf("%s trial %0d mode", name, k), cur_mode, seq[2*k +: 2]);
      i = 0;
      cost_seen = 1'b0;
      to = 0;
      while (i < 256 && to < 4000) begin
        if (cost_ready) cost_seen = 1'b1;
        in_valid = ((i % 5) != 3) || (to % 2 == 0);
        in_data = pat(int'(cur_mode), i);
        start = stray && (k == 0) && (i == 100);
        if (start) avail = 2'b00;
        if (in_valid && in_ready) i++;
        to++;
        @(negedge clk);
      end
      in_valid = 1'b0;
      start = 1'b0;
      check(!cost_seen && i == 256, "R4",
            $sformatf("%s trial %0d samples", name, k), i, 256);
      to = 0;
      while (!cost_ready && to < 2000) begin
        @(negedge clk);
        to++;
      end
      check(cost_ready && !in_ready, "R4",
            $sformatf("%s trial %0d cost wait", name, k), cost_ready, 1);
      cost_valid = 1'b1;
      cost_data = 16'(costs[k]);
      @(negedge clk);
      cost_valid = 1'b0;
    end
    to = 0;
    while (!out_valid && to < 2000) begin
      @(negedge clk);
      to++;
    end
    check(done === 1'b1, "R6", {name, " done with first word"}, done, 1);
    check(int'(best_mode) == exp_best, "R5", {name, " chosen mode"}, best_mode, exp_best);
    bad_data = 0;
    bad_last = 0;
    bad_hold = 0;
    held = 1'b0;
    held_data = '0;
    begin
      int j;
      j = 0;
      to = 0;
      while (j < 256 && to < 4000) begin
        if (held && (!out_valid || out_data !== held_data)) bad_hold++;
        out_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
        if (out_valid && out_ready) begin
          if (out_data !== pat(exp_best, j)) bad_data++;
          if (out_last !== (j == 255)) bad_last++;
          j++;
          held = 1'b0;
        end else if (out_valid) begin
          held = 1'b1;
          held_data = out_data;
        end
        to++;
        @(negedge clk);
      end
      out_ready = 1'b0;
      check(j == 256 && bad_data == 0, "R7", {name, " residual stream"}, bad_data, 0);
      check(bad_last == 0, "R7", {name, " last flag"}, bad_last, 0);
      if (stall) check(bad_hold == 0, "R8", {name, " stall hold"}, bad_hold, 0);
    end
    check(!busy && !out_valid && !done, "R1", {name, " back to idle"}, busy, 0);
    check(int'(best_mode) == exp_best, "R6", {name, " mode held after run"},
          best_mode, exp_best);
  endtask

  task automatic t_reset();
    check(!busy && !in_ready && !cost_ready && !out_valid && !done, "R1",
          "reset outputs quiet", {busy, in_ready, cost_ready, out_valid, done}, 0);
  endtask

  initial begin
    int c[4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    // R2: no neighbours, only DC
    c = '{500, 0, 0, 0};
    run_case("none", 2'b00, 8'b00_00_00_10, 1, c, 1'b0, 1'b0);
    // R2 R3: all four, plane cheapest
    c = '{100, 80, 90, 70};
    run_case("all_plane", 2'b11, 8'b11_00_01_10, 4, c, 1'b0, 1'b0);
    // R5: ties keep the earliest
    c = '{50, 50, 50, 60};
    run_case("ties", 2'b11, 8'b11_00_01_10, 4, c, 1'b1, 1'b0);
    // R2: top only gives DC then vertical
    c = '{40, 30, 0, 0};
    run_case("top", 2'b10, 8'b00_00_00_10, 2, c, 1'b0, 1'b0);
    // R2 R8: left only with output stalls, DC wins
    c = '{10, 20, 0, 0};
    run_case("left", 2'b01, 8'b00_00_01_10, 2, c, 1'b1, 1'b0);
    // R5: winner followed by losers overwriting the spare memory
    c = '{50, 40, 45, 60};
    run_case("keep_h", 2'b11, 8'b11_00_01_10, 4, c, 1'b1, 1'b0);
    // R9: stray start mid-run is ignored
    c = '{65535, 300, 200, 250};
    run_case("stray", 2'b11, 8'b11_00_01_10, 4, c, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule